// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences the transfers of a single DMA channel. It holds the working source address, destination address and unit counter, plus backup copies of the two addresses and of the count. For each request it decides whether a transfer unit may begin. It hands the current addresses and size to a bus master with a one-cycle start pulse. It waits for the master's done pulse, then steps the addresses and counts the unit down.

Three operating modes are supported. In normal mode the channel stops at completion. In repeat mode, completion restores the counter and addresses from the backups, and under a half-flag rule the channel keeps serving requests. In reload mode, the addresses are restored from the backups each time the low byte of the counter returns to zero. Sticky completion and half-way flags drive pulse interrupts. An NMI flag, an address-error flag, or clearing either enable blocks further starts.

Top module: `dma_chan_seq`

Register writes use `wr_sel`:
- 0 = source address
- 1 = destination address
- 2 = counter
- 3 = control
- 4 = backup source
- 5 = backup destination
- 6 = backup count
- 7 = global

Control bits:
- [0] channel enable
- [1] end interrupt enable
- [2] half interrupt enable
- [3] end flag
- [4] half flag
- [6:5] source address mode
- [8:7] destination address mode
- [10:9] size code
- [12:11] operating mode

Global bits:
- [0] master enable
- [1] NMI flag
- [2] address-error flag

Address mode codes are 0 fixed, 1 increment, 2 decrement and 3 fixed. The step is `1 << size code` bytes. Operating mode codes are 0 normal, 1 repeat, 2 reload and 3 normal.

## Requirements
- R1: After reset the counter reads 0, both flags read 0, and no start or interrupt pulse is issued.
- R2: A start is issued on a request only when channel enable (control bit 0) and master enable (global bit 0) are 1, the NMI and address-error flags (global bits 1, 2) are 0, and the end flag is 0 (except as in R8).
- R3: `start` is high for exactly one cycle and carries the working addresses and size code. No further start is issued until `done` has been seen.
- R4: On each `done` the counter decrements by one, and each address moves by its own mode: unchanged (code 0 or 3), increased (1) or decreased (2) by `1 << size` bytes.
- R5: When the decremented counter is 0, the end flag is set, and `irq_end` pulses for one cycle if control bit 1 is 1.
- R6: When the decremented counter is nonzero and equals the backup count shifted right by one, the half flag is set, and `irq_half` pulses if control bit 2 is 1.
- R7: In repeat mode (code 1), completion loads the counter from the backup count and both addresses from the backup addresses, unless an abort condition (R11) is present.
- R8: In repeat mode with the end flag at 1, a request is still accepted when control bit 2 is 1 and the half flag is 0. Otherwise the channel stays stopped.
- R9: In reload mode (code 2), whenever a unit leaves counter bits [7:0] at 0, both addresses are loaded from the backups and backup count bits [23:16] are copied into backup count bits [7:0]. Backup count bits [7:0] otherwise decrement with each unit. The counter itself keeps counting down.
- R10: The end and half flags are sticky. A control write with the flag's bit at 0 clears it, and a write with the bit at 1 leaves it unchanged.
- R11: An NMI flag of 1, an address-error flag of 1, channel enable at 0 or master enable at 0 each prevent any new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | DW | Write data |
| req | input | 1 | Transfer request |
| start | output | 1 | One-cycle start pulse to the bus master |
| start_src | output | AW | Source address for the unit being started |
| start_dst | output | AW | Destination address for the unit being started |
| start_size | output | 2 | Size code for the unit being started |
| done | input | 1 | Unit completed by the bus master |
| irq_end | output | 1 | Completion interrupt pulse |
| irq_half | output | 1 | Half-way interrupt pulse |
| te_flag | output | 1 | Sticky end flag |
| he_flag | output | 1 | Sticky half flag |
| count | output | CW | Working unit counter |

## Verification
A wrong counter or backup value shows up one cycle after the `done` that exposes it. It appears as a wrong `count`, a missing or misplaced flag, or an interrupt pulse at the wrong unit. A wrong address or mode decode is seen at the next `start` pulse, through `start_src` and `start_dst`. A faulty start gate shows up within a few cycles of a held request, as a start that should not appear or one that never comes. A corrupted reload path in repeat or reload mode becomes visible only at the first start after the reload point, so those cases are driven right up to that unit.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
   typedef enum logic [1:0] {
      AM_FIXED = 2'd0,
      AM_INC   = 2'd1,
      AM_DEC   = 2'd2,
      AM_HOLD  = 2'd3
   } addr_mode_e;

   typedef enum logic [1:0] {
      OP_NORMAL = 2'd0,
      OP_REPEAT = 2'd1,
      OP_RELOAD = 2'd2,
      OP_SPARE  = 2'd3
   } op_mode_e;

   localparam logic [2:0] SEL_SRC    = 3'd0;
   localparam logic [2:0] SEL_DST    = 3'd1;
   localparam logic [2:0] SEL_CNT    = 3'd2;
   localparam logic [2:0] SEL_CTRL   = 3'd3;
   localparam logic [2:0] SEL_SRCBK  = 3'd4;
   localparam logic [2:0] SEL_DSTBK  = 3'd5;
   localparam logic [2:0] SEL_CNTBK  = 3'd6;
   localparam logic [2:0] SEL_GLOBAL = 3'd7;

   // reload sub-fields of the backup count
   localparam int RL_LO = 0;
   localparam int RL_HI = 16;
   localparam int RL_W  = 8;
endpackage

// File: rtl/dmaseq_step.sv
module dmaseq_step #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] addr_i,
   input  logic [1:0]    mode_i,
   input  logic [1:0]    size_i,
   output logic [AW-1:0] addr_o
);
   import dmaseq_pkg::*;

   logic [AW-1:0] step;
   assign step = {{(AW-1){1'b0}}, 1'b1} << size_i;

   always_comb begin
      case (addr_mode_e'(mode_i))
         AM_INC:  addr_o = addr_i + step;
         AM_DEC:  addr_o = addr_i - step;
         default: addr_o = addr_i;
      endcase
   end
endmodule

// File: rtl/dmaseq_gate.sv
module dmaseq_gate (
   input  logic       chan_en_i,
   input  logic       master_en_i,
   input  logic       nmi_i,
   input  logic       aerr_i,
   input  logic       te_i,
   input  logic       he_i,
   input  logic       hie_i,
   input  logic [1:0] op_i,
   output logic       go_o
);
   import dmaseq_pkg::*;

   logic enabled, rep_pass;

   assign enabled  = chan_en_i & master_en_i & ~nmi_i & ~aerr_i;
   assign rep_pass = (op_mode_e'(op_i) == OP_REPEAT) & hie_i & ~he_i;
   assign go_o     = enabled & (~te_i | rep_pass);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
   parameter int AW = 32,
   parameter int CW = 24,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_sel,
   input  logic [DW-1:0] wr_data,
   input  logic          req,
   output logic          start,
   output logic [AW-1:0] start_src,
   output logic [AW-1:0] start_dst,
   output logic [1:0]    start_size,
   input  logic          done,
   output logic          irq_end,
   output logic          irq_half,
   output logic          te_flag,
   output logic          he_flag,
   output logic [CW-1:0] count
);
   import dmaseq_pkg::*;

   localparam int NDIR = 2;

   if (CW < RL_HI + RL_W) begin : g_cw_chk
      $error("dma_chan_seq: CW must cover the reload fields");
   end
   if (CW > DW || AW > DW) begin : g_dw_chk
      $error("dma_chan_seq: register width exceeds DW");
   end
   if (AW < 4) begin : g_aw_chk
      $error("dma_chan_seq: AW too small for an 8-byte step");
   end

   logic [AW-1:0] addr_q  [NDIR];
   logic [AW-1:0] bk_q    [NDIR];
   logic [AW-1:0] step_a  [NDIR];
   logic [1:0]    amode_q [NDIR];
   logic [CW-1:0] cnt_q, cntbk_q, cnt_dec;
   logic [1:0]    size_q, op_q;
   logic          en_q, ie_q, hie_q, te_q, he_q;
   logic          men_q, nmi_q, aerr_q;
   logic          busy_q, go, upd, at_zero, at_half, rl_hit, stop, rep_back;

   for (genvar g = 0; g < NDIR; g++) begin : g_dir
      dmaseq_step #(.AW(AW)) u_step (
         .addr_i (addr_q[g]),
         .mode_i (amode_q[g]),
         .size_i (size_q),
         .addr_o (step_a[g])
      );
   end

   dmaseq_gate u_gate (
      .chan_en_i   (en_q),
      .master_en_i (men_q),
      .nmi_i       (nmi_q),
      .aerr_i      (aerr_q),
      .te_i        (te_q),
      .he_i        (he_q),
      .hie_i       (hie_q),
      .op_i        (op_q),
      .go_o        (go)
   );

   assign upd      = busy_q & done;
   assign cnt_dec  = cnt_q - {{(CW-1){1'b0}}, 1'b1};
   assign at_zero  = (cnt_dec == '0);
   assign at_half  = (cnt_dec == (cntbk_q >> 1));
   assign rl_hit   = (op_mode_e'(op_q) == OP_RELOAD) && (cnt_dec[RL_LO +: RL_W] == '0);
   assign stop     = nmi_q | aerr_q | ~en_q | ~men_q;
   assign rep_back = at_zero && (op_mode_e'(op_q) == OP_REPEAT) && !stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NDIR; i++) begin
            addr_q[i]  <= '0;
            bk_q[i]    <= '0;
            amode_q[i] <= '0;
         end
         cnt_q      <= '0;
         cntbk_q    <= '0;
         size_q     <= '0;
         op_q       <= '0;
         en_q       <= 1'b0;
         ie_q       <= 1'b0;
         hie_q      <= 1'b0;
         te_q       <= 1'b0;
         he_q       <= 1'b0;
         men_q      <= 1'b0;
         nmi_q      <= 1'b0;
         aerr_q     <= 1'b0;
         busy_q     <= 1'b0;
         start      <= 1'b0;
         start_src  <= '0;
         start_dst  <= '0;
         start_size <= '0;
         irq_end    <= 1'b0;
         irq_half   <= 1'b0;
      end else begin
         start    <= 1'b0;
         irq_end  <= 1'b0;
         irq_half <= 1'b0;

         if (!busy_q && req && go) begin
            start      <= 1'b1;
            busy_q     <= 1'b1;
            start_src  <= addr_q[0];
            start_dst  <= addr_q[1];
            start_size <= size_q;
         end

         if (upd) begin
            busy_q <= 1'b0;
            cnt_q  <= rep_back ? cntbk_q : cnt_dec;
            for (int i = 0; i < NDIR; i++)
               addr_q[i] <= (rep_back || rl_hit) ? bk_q[i] : step_a[i];
            if (op_mode_e'(op_q) == OP_RELOAD)
               cntbk_q[RL_LO +: RL_W] <= rl_hit ? cntbk_q[RL_HI +: RL_W]
                                                : cntbk_q[RL_LO +: RL_W] - 8'd1;
            if (at_zero) begin
               te_q    <= 1'b1;
               irq_end <= ie_q;
            end else if (at_half) begin
               he_q     <= 1'b1;
               irq_half <= hie_q;
            end
         end

         if (wr_en) begin
            case (wr_sel)
               SEL_SRC:   addr_q[0] <= wr_data[AW-1:0];
               SEL_DST:   addr_q[1] <= wr_data[AW-1:0];
               SEL_CNT:   cnt_q     <= wr_data[CW-1:0];
               SEL_SRCBK: bk_q[0]   <= wr_data[AW-1:0];
               SEL_DSTBK: bk_q[1]   <= wr_data[AW-1:0];
               SEL_CNTBK: cntbk_q   <= wr_data[CW-1:0];
               SEL_CTRL: begin
                  en_q       <= wr_data[0];
                  ie_q       <= wr_data[1];
                  hie_q      <= wr_data[2];
                  te_q       <= te_q & wr_data[3];
                  he_q       <= he_q & wr_data[4];
                  amode_q[0] <= wr_data[6:5];
                  amode_q[1] <= wr_data[8:7];
                  size_q     <= wr_data[10:9];
                  op_q       <= wr_data[12:11];
               end
               default: begin
                  men_q  <= wr_data[0];
                  nmi_q  <= wr_data[1];
                  aerr_q <= wr_data[2];
               end
            endcase
         end
      end
   end

   assign te_flag = te_q;
   assign he_flag = he_q;
   assign count   = cnt_q;
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
   parameter int CW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          start,
   input logic          done,
   input logic          busy,
   input logic          en,
   input logic          men,
   input logic          nmi,
   input logic          aerr,
   input logic          irq_end,
   input logic          irq_half,
   input logic          te_flag,
   input logic          he_flag,
   input logic [CW-1:0] count
);
   assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);

   assert_no_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !start);

   assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> $past(en && men && !nmi && !aerr));

   assert_count_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(count) && !$past(wr_en)) |-> $past(done && busy));

   assert_end_irq_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_end |-> te_flag);

   assert_half_irq_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_half |-> he_flag);

   assert_te_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(te_flag) |-> $past(wr_en));

   assert_he_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(he_flag) |-> $past(wr_en));
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .start    (start),
   .done     (done),
   .busy     (busy_q),
   .en       (en_q),
   .men      (men_q),
   .nmi      (nmi_q),
   .aerr     (aerr_q),
   .irq_end  (irq_end),
   .irq_half (irq_half),
   .te_flag  (te_flag),
   .he_flag  (he_flag),
   .count    (count)
);

// File: tb/dma_chan_seq_tb.sv
`timescale 1ns/1ps
module dma_chan_seq_tb;
   localparam int AW = 32;
   localparam int CW = 24;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_sel = '0;
   logic [DW-1:0] wr_data = '0;
   logic          req = 1'b0;
   logic          done = 1'b0;
   logic          start, irq_end, irq_half, te_flag, he_flag;
   logic [AW-1:0] start_src, start_dst;
   logic [1:0]    start_size;
   logic [CW-1:0] count;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   dma_chan_seq #(.AW(AW), .CW(CW), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .req(req), .start(start), .start_src(start_src), .start_dst(start_dst),
      .start_size(start_size), .done(done), .irq_end(irq_end), .irq_half(irq_half),
      .te_flag(te_flag), .he_flag(he_flag), .count(count)
   );

   // {src mode, dst mode, size, pad, expected 2nd src[15:0], expected 2nd dst[15:0]}
   localparam logic [39:0] VEC [6] = '{
      {2'd1, 2'd1, 2'd0, 2'd0, 16'h1001, 16'h2001},
      {2'd0, 2'd1, 2'd2, 2'd0, 16'h1000, 16'h2004},
      {2'd2, 2'd0, 2'd3, 2'd0, 16'h0FF8, 16'h2000},
      {2'd1, 2'd2, 2'd1, 2'd0, 16'h1002, 16'h1FFE},
      {2'd2, 2'd2, 2'd0, 2'd0, 16'h0FFF, 16'h1FFF},
      {2'd3, 2'd3, 2'd3, 2'd0, 16'h1000, 16'h2000}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_ctrl(input bit en, input bit ie, input bit hie,
                                           input bit te, input bit he, input logic [1:0] sm,
                                           input logic [1:0] dm, input logic [1:0] sz,
                                           input logic [1:0] op);
      return {19'd0, op, sz, dm, sm, he, te, hie, ie, en};
   endfunction

   task automatic wr(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic unit(input bit exp_start, input logic [31:0] es, input logic [31:0] ed,
                       input string tag);
      bit seen = 0;
      req = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (start) begin seen = 1; break; end
      end
      req = 1'b0;
      if (!exp_start) begin
         chk(tag, 64'(seen), 64'd0);
         return;
      end
      chk(tag, 64'(seen), 64'd1);
      if (!seen) return;
      chk(tag, 64'(start_src), 64'(es));
      chk(tag, 64'(start_dst), 64'(ed));
      @(negedge clk);
      chk("R3 start one cycle", 64'(start), 64'd0);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 count", 64'(count), 64'd0);
      chk("R1 te", 64'(te_flag), 64'd0);
      chk("R1 he", 64'(he_flag), 64'd0);
      chk("R1 start", 64'(start), 64'd0);
      chk("R1 irq", 64'({irq_end, irq_half}), 64'd0);

      // R2: master enable off blocks, then on allows
      wr(3'd0, 32'h1000); wr(3'd1, 32'h2000); wr(3'd2, 32'd4);
      wr(3'd3, mk_ctrl(1, 0, 0, 0, 0, 2'd1, 2'd1, 2'd0, 2'd0));
      unit(0, 0, 0, "R2 master off");
      wr(3'd7, 32'h1);
      unit(1, 32'h1000, 32'h2000, "R2 master on");
      chk("R4 count dec", 64'(count), 64'd3);

      // R4: address modes and sizes from the table
      foreach (VEC[k]) begin
         wr(3'd0, 32'h1000); wr(3'd1, 32'h2000); wr(3'd2, 32'd4);
         wr(3'd3, mk_ctrl(1, 0, 0, 0, 0, VEC[k][39:38], VEC[k][37:36], VEC[k][35:34], 2'd0));
         unit(1, 32'h1000, 32'h2000, "R4 first");
         chk("R4 size", 64'(start_size), 64'(VEC[k][35:34]));
         unit(1, {16'd0, VEC[k][31:16]}, {16'd0, VEC[k][15:0]}, "R4 step");
      end

      // R5/R6 normal completion with half
      wr(3'd0, 32'h40); wr(3'd1, 32'h80); wr(3'd2, 32'd4); wr(3'd6, 32'd4);
      wr(3'd3, mk_ctrl(1, 1, 1, 0, 0, 2'd1, 2'd1, 2'd0, 2'd0));
      unit(1, 32'h40, 32'h80, "R4 u1");
      chk("R6 no half yet", 64'(he_flag), 64'd0);
      unit(1, 32'h41, 32'h81, "R4 u2");
      chk("R6 irq_half", 64'(irq_half), 64'd1);
      chk("R6 he_flag", 64'(he_flag), 64'd1);
      unit(1, 32'h42, 32'h82, "R4 u3");
      chk("R6 irq_half once", 64'(irq_half), 64'd0);
      unit(1, 32'h43, 32'h83, "R4 u4");
      chk("R5 irq_end", 64'(irq_end), 64'd1);
      chk("R5 te_flag", 64'(te_flag), 64'd1);
      chk("R5 count zero", 64'(count), 64'd0);
      @(negedge clk);
      chk("R5 irq_end pulse", 64'(irq_end), 64'd0);
      unit(0, 0, 0, "R2 te blocks normal");
      // R10: write 1 keeps, write 0 clears
      wr(3'd3, mk_ctrl(1, 1, 1, 1, 1, 2'd1, 2'd1, 2'd0, 2'd0));
      chk("R10 te kept", 64'(te_flag), 64'd1);
      chk("R10 he kept", 64'(he_flag), 64'd1);
      wr(3'd3, mk_ctrl(1, 1, 1, 0, 0, 2'd1, 2'd1, 2'd0, 2'd0));
      chk("R10 te cleared", 64'(te_flag), 64'd0);
      chk("R10 he cleared", 64'(he_flag), 64'd0);

      // R7/R8 repeat mode
      wr(3'd0, 32'h10); wr(3'd1, 32'h20); wr(3'd2, 32'd2); wr(3'd6, 32'd2);
      wr(3'd4, 32'h3000); wr(3'd5, 32'h4000);
      wr(3'd3, mk_ctrl(1, 1, 1, 0, 0, 2'd1, 2'd1, 2'd0, 2'd1));
      unit(1, 32'h10, 32'h20, "R7 u1");
      chk("R6 repeat half", 64'(he_flag), 64'd1);
      unit(1, 32'h11, 32'h21, "R7 u2");
      chk("R7 count reload", 64'(count), 64'd2);
      chk("R5 repeat te", 64'(te_flag), 64'd1);
      unit(0, 0, 0, "R8 he set stops");
      wr(3'd3, mk_ctrl(1, 1, 1, 1, 0, 2'd1, 2'd1, 2'd0, 2'd1));
      chk("R10 te kept on 1", 64'(te_flag), 64'd1);
      unit(1, 32'h3000, 32'h4000, "R8 continue from backup R7");
      chk("R8 count", 64'(count), 64'd1);

      // R9 reload mode
      wr(3'd3, mk_ctrl(1, 0, 0, 0, 0, 2'd1, 2'd1, 2'd0, 2'd2));
      wr(3'd0, 32'h100); wr(3'd1, 32'h200); wr(3'd2, 32'h101); wr(3'd6, 32'h020002);
      wr(3'd4, 32'h500); wr(3'd5, 32'h600);
      unit(1, 32'h100, 32'h200, "R9 u1");
      chk("R9 count", 64'(count), 64'h100);
      unit(1, 32'h500, 32'h600, "R9 reloaded addr");
      chk("R9 count continues", 64'(count), 64'hFF);
      unit(1, 32'h501, 32'h601, "R9 steps after reload");

      // R11 abort conditions
      wr(3'd2, 32'd8);
      wr(3'd3, mk_ctrl(1, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0, 2'd0));
      wr(3'd7, 32'h3);
      unit(0, 0, 0, "R11 nmi");
      wr(3'd7, 32'h5);
      unit(0, 0, 0, "R11 addr error");
      wr(3'd7, 32'h1);
      wr(3'd3, mk_ctrl(0, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0, 2'd0));
      unit(0, 0, 0, "R11 chan disabled");
      wr(3'd3, mk_ctrl(1, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0, 2'd0));
      wr(3'd7, 32'h0);
      unit(0, 0, 0, "R11 master disabled");
      chk("R11 count untouched", 64'(count), 64'd8);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule